// File: doc/BRIEF.md
# Tape Formatter Register File and Command Decoder

This block is the register front end of a magnetic tape formatter on a peripheral register bus. A host reads and writes 16-bit registers by a 5-bit register number, with one strobe per cycle. The block keeps the function/control register, the error register, a maintenance register, the frame counter, the tape control register and one attention flag. It decodes the function code written with the GO bit. It then either starts an operation, with a one-cycle start pulse and the function code sent to a separate motion engine, or records an error.

While an operation is in progress (GO or positioning-in-progress set), every register write is refused and flagged. The motion engine ends the operation with a one-cycle `op_done`. The drive status word is built from internal state and from the drive inputs: attached, write-locked, beginning of tape and end of tape. Data transfer and tape motion are outside this block.

Top module: `tape_fmt_regs`

## Requirements
- R1: Register 0 (control) stores bits 5:1 of every accepted write as the function code. Reading register 0 returns the GO bit in bit 0, the function in bits 5:1 and bit 11 set, with all other bits 0. A write with bit 0 clear starts nothing.
- R2: With a tape attached and GO written, any function code other than octal 00, 01, 03, 04, 10, 12, 13, 14, 15, 24, 27, 30, 34 and 37 sets error bit 0 and raises attention. Register 4 bit 0 and status bit 15 show the attention flag.
- R3: A write to any register while GO or positioning-in-progress is set changes no register and sets error bit 2.
- R4: Codes 10, 34 and 37 clear the frame counter (register 5), set the frame-count-valid bit 14 of the tape control register (register 9) and start.
- R5: Codes 30, 14 and 15 start only when tape-control bit 14 is already set. Otherwise they set error bit 11 and do not start.
- R6: Codes 01, 03, 12, 13, 24 and 27 always start, and codes 10, 34, 37 (and 30, 14, 15 when allowed) start as well. A start raises `start_pulse` for the one cycle after the write, with `start_func` holding the code. It sets GO and positioning-in-progress (status bit 13), sets tape-control bit 15 and clears the error register. Code 00 and code 04 never start.
- R7: Code 04 (drive clear) with GO clears the attention flag. With a tape attached it also clears the error register and tape-control bit 14.
- R8: A write to register 5 loads the frame counter and sets tape-control bit 14. A write to register 4 with bit 0 set clears attention; with bit 0 clear it has no effect.
- R9: Status (register 1) always has bit 8 set. It has bit 15 = attention, bit 14 = error register non-zero and bit 13 = positioning-in-progress. When attached it also sets bit 12, bit 11 = write-locked, bit 10 = end of tape, bit 7 when neither GO nor positioning is active, bit 5 when tape-control bits 10:8 equal 100b, bit 4 when GO is clear, and bit 1 = beginning of tape.
- R10: Register 6 reads octal 142054. Register 7 reads 0. Register 8 reads octal 20 plus the unit number plus one, where the unit is tape-control bits 2:0.
- R11: After reset the tape control register reads octal 2000 and status reads octal 400 with no tape attached. A read or write of a register number other than 0 to 9 (octal 0 to 11) sets error bit 1 and raises attention, and such a read returns 0.
- R12: `op_done` clears GO, positioning-in-progress and tape-control bit 15.
- R13: With no tape attached, a GO write of any code other than 04 starts nothing and records no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| drv_attached | input | 1 | Tape mounted and online |
| drv_wlock | input | 1 | Tape write-locked |
| drv_bot | input | 1 | Tape at beginning |
| drv_eot | input | 1 | Tape past end marker |
| op_done | input | 1 | Motion engine finished the operation |
| start_pulse | output | 1 | One-cycle start to the motion engine |
| start_func | output | 5 | Function code of the operation |
| attn_out | output | 1 | Attention flag |

## Verification
Every strobe takes effect at the clock edge that samples it. The bench drives each strobe for exactly one cycle from the falling edge. It reads the effect at the next falling edge: read data, the start pulse and the changed registers are all due one cycle after the strobe. The start pulse lasts only that one cycle, so it is checked right after the write task returns and before any other strobe. Status and register values are always fetched through a fresh read, never inferred from earlier ones.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int FN_W   = 5;

  // register numbers
  localparam logic [ADDR_W-1:0] RA_CTRL  = 5'o00;
  localparam logic [ADDR_W-1:0] RA_STAT  = 5'o01;
  localparam logic [ADDR_W-1:0] RA_ERR   = 5'o02;
  localparam logic [ADDR_W-1:0] RA_MAINT = 5'o03;
  localparam logic [ADDR_W-1:0] RA_ATTN  = 5'o04;
  localparam logic [ADDR_W-1:0] RA_FCNT  = 5'o05;
  localparam logic [ADDR_W-1:0] RA_DTYPE = 5'o06;
  localparam logic [ADDR_W-1:0] RA_LOOK  = 5'o07;
  localparam logic [ADDR_W-1:0] RA_SER   = 5'o10;
  localparam logic [ADDR_W-1:0] RA_TCTL  = 5'o11;

  // error bits
  localparam int E_BADFN  = 0;
  localparam int E_BADREG = 1;
  localparam int E_REFUSE = 2;
  localparam int E_NOEXEC = 11;

  // tape control fields
  localparam int TC_FCV  = 14;
  localparam int TC_ACC  = 15;
  localparam int TC_DLO  = 8;
  localparam logic [2:0] DENS_PE = 3'b100;
  localparam logic [REG_W-1:0] TC_RESET  = 16'o002000;
  localparam logic [REG_W-1:0] DTYPE_VAL = 16'o142054;

  // function codes
  localparam logic [FN_W-1:0] FN_NOP    = 5'o00;
  localparam logic [FN_W-1:0] FN_UNLOAD = 5'o01;
  localparam logic [FN_W-1:0] FN_REWIND = 5'o03;
  localparam logic [FN_W-1:0] FN_DCLR   = 5'o04;
  localparam logic [FN_W-1:0] FN_PRESET = 5'o10;
  localparam logic [FN_W-1:0] FN_ERASE  = 5'o12;
  localparam logic [FN_W-1:0] FN_TMARK  = 5'o13;
  localparam logic [FN_W-1:0] FN_SPCF   = 5'o14;
  localparam logic [FN_W-1:0] FN_SPCR   = 5'o15;
  localparam logic [FN_W-1:0] FN_WCHK   = 5'o24;
  localparam logic [FN_W-1:0] FN_WCHKR  = 5'o27;
  localparam logic [FN_W-1:0] FN_WRITE  = 5'o30;
  localparam logic [FN_W-1:0] FN_READ   = 5'o34;
  localparam logic [FN_W-1:0] FN_READR  = 5'o37;

  typedef enum logic [2:0] {
    CL_IDLE, CL_CLEAR, CL_PLAIN, CL_NEEDFC, CL_LOADFC, CL_BAD
  } fn_class_e;

  typedef struct packed {
    logic attached;
    logic wlock;
    logic bot;
    logic eot;
  } drv_in_t;

  function automatic fn_class_e classify(input logic [FN_W-1:0] f);
    fn_class_e c;
    case (f)
      FN_NOP:                                             c = CL_IDLE;
      FN_DCLR:                                            c = CL_CLEAR;
      FN_PRESET, FN_READ, FN_READR:                       c = CL_LOADFC;
      FN_WRITE, FN_SPCF, FN_SPCR:                         c = CL_NEEDFC;
      FN_UNLOAD, FN_REWIND, FN_ERASE, FN_TMARK,
      FN_WCHK, FN_WCHKR:                                  c = CL_PLAIN;
      default:                                            c = CL_BAD;
    endcase
    return c;
  endfunction

  function automatic logic [REG_W-1:0] compose_status(
      input drv_in_t d, input logic go, input logic pip,
      input logic attn, input logic err_nz, input logic [2:0] dens);
    logic [REG_W-1:0] s;
    s     = '0;
    s[8]  = 1'b1;
    s[15] = attn;
    s[14] = err_nz;
    s[13] = pip;
    if (d.attached) begin
      s[12] = 1'b1;
      s[11] = d.wlock;
      s[10] = d.eot;
      s[7]  = !go && !pip;
      s[5]  = (dens == DENS_PE);
      s[4]  = !go;
      s[1]  = d.bot;
    end
    return s;
  endfunction

  function automatic logic [REG_W-1:0] serial_of(input logic [2:0] unit);
    return 16'o20 + {13'd0, unit} + 16'd1;
  endfunction
endpackage

// File: rtl/tfr_decode.sv
module tfr_decode
  import tfr_pkg::*;
(
  input  logic [FN_W-1:0] func,
  input  logic            fcv,
  output logic            dec_start,
  output logic            dec_loadfc,
  output logic            dec_clear,
  output logic            dec_noexec,
  output logic            dec_bad
);
  fn_class_e cls;
  always_comb begin
    cls        = classify(func);
    dec_loadfc = (cls == CL_LOADFC);
    dec_clear  = (cls == CL_CLEAR);
    dec_bad    = (cls == CL_BAD);
    dec_noexec = (cls == CL_NEEDFC) && !fcv;
    dec_start  = (cls == CL_PLAIN) || (cls == CL_LOADFC) ||
                 ((cls == CL_NEEDFC) && fcv);
  end
endmodule

// File: rtl/tfr_status.sv
module tfr_status
  import tfr_pkg::*;
(
  input  drv_in_t          drv,
  input  logic             go,
  input  logic             pip,
  input  logic             attn,
  input  logic             err_nz,
  input  logic [2:0]       dens,
  output logic [REG_W-1:0] status_word
);
  always_comb status_word = compose_status(drv, go, pip, attn, err_nz, dens);
endmodule

// File: rtl/tfr_rdmux.sv
module tfr_rdmux
  import tfr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [FN_W-1:0]   func,
  input  logic              go,
  input  logic [REG_W-1:0]  status_word,
  input  logic [REG_W-1:0]  err,
  input  logic [REG_W-1:0]  maint,
  input  logic              attn,
  input  logic [REG_W-1:0]  fcnt,
  input  logic [REG_W-1:0]  tctl,
  output logic [REG_W-1:0]  rd_data,
  output logic              addr_bad
);
  always_comb begin
    addr_bad = 1'b0;
    case (addr)
      RA_CTRL:  rd_data = {4'd0, 1'b1, 5'd0, func, go};
      RA_STAT:  rd_data = status_word;
      RA_ERR:   rd_data = err;
      RA_MAINT: rd_data = maint;
      RA_ATTN:  rd_data = {{(REG_W-1){1'b0}}, attn};
      RA_FCNT:  rd_data = fcnt;
      RA_DTYPE: rd_data = DTYPE_VAL;
      RA_LOOK:  rd_data = '0;
      RA_SER:   rd_data = serial_of(tctl[2:0]);
      RA_TCTL:  rd_data = tctl;
      default: begin
        rd_data  = '0;
        addr_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tape_fmt_regs.sv
module tape_fmt_regs
  import tfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              drv_attached,
  input  logic              drv_wlock,
  input  logic              drv_bot,
  input  logic              drv_eot,
  input  logic              op_done,
  output logic              start_pulse,
  output logic [FN_W-1:0]   start_func,
  output logic              attn_out
);
  logic             go_q, pip_q, attn_q;
  logic [FN_W-1:0]  func_q;
  logic [REG_W-1:0] err_q, maint_q, fcnt_q, tctl_q;

  logic [REG_W-1:0] status_word, rd_mux;
  logic             addr_bad;
  logic             dec_start, dec_loadfc, dec_clear, dec_noexec, dec_bad;
  drv_in_t          drv;

  // named internal events
  logic busy, wr_ok, ctl_go;
  logic ev_start, ev_noexec, ev_illegal_func, ev_dclr, ev_refused, ev_illegal_reg;

  assign drv = '{attached: drv_attached, wlock: drv_wlock, bot: drv_bot, eot: drv_eot};

  tfr_decode u_dec (
    .func(bus_wdata[FN_W:1]), .fcv(tctl_q[TC_FCV]),
    .dec_start(dec_start), .dec_loadfc(dec_loadfc), .dec_clear(dec_clear),
    .dec_noexec(dec_noexec), .dec_bad(dec_bad)
  );

  tfr_status u_stat (
    .drv(drv), .go(go_q), .pip(pip_q), .attn(attn_q),
    .err_nz(err_q != '0), .dens(tctl_q[TC_DLO+2:TC_DLO]),
    .status_word(status_word)
  );

  tfr_rdmux u_rd (
    .addr(bus_addr), .func(func_q), .go(go_q), .status_word(status_word),
    .err(err_q), .maint(maint_q), .attn(attn_q), .fcnt(fcnt_q), .tctl(tctl_q),
    .rd_data(rd_mux), .addr_bad(addr_bad)
  );

  always_comb begin
    busy            = go_q || pip_q;
    wr_ok           = bus_wr && !busy;
    ctl_go          = wr_ok && (bus_addr == RA_CTRL) && bus_wdata[0];
    ev_start        = ctl_go && drv_attached && dec_start;
    ev_noexec       = ctl_go && drv_attached && dec_noexec;
    ev_illegal_func = ctl_go && drv_attached && dec_bad;
    ev_dclr         = ctl_go && dec_clear;
    ev_refused      = bus_wr && busy;
    ev_illegal_reg  = (wr_ok || bus_rd) && addr_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q        <= 1'b0;
      pip_q       <= 1'b0;
      attn_q      <= 1'b0;
      func_q      <= '0;
      err_q       <= '0;
      maint_q     <= '0;
      fcnt_q      <= '0;
      tctl_q      <= TC_RESET;
      start_pulse <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      start_pulse <= ev_start;
      if (op_done) begin
        go_q           <= 1'b0;
        pip_q          <= 1'b0;
        tctl_q[TC_ACC] <= 1'b0;
      end
      if (ev_refused) err_q[E_REFUSE] <= 1'b1;
      if (wr_ok) begin
        case (bus_addr)
          RA_CTRL: begin
            func_q <= bus_wdata[FN_W:1];
            if (ev_start) begin
              go_q           <= 1'b1;
              pip_q          <= 1'b1;
              tctl_q[TC_ACC] <= 1'b1;
              err_q          <= '0;
              if (dec_loadfc) begin
                fcnt_q         <= '0;
                tctl_q[TC_FCV] <= 1'b1;
              end
            end
            if (ev_noexec) err_q[E_NOEXEC] <= 1'b1;
            if (ev_illegal_func) begin
              err_q[E_BADFN] <= 1'b1;
              attn_q         <= 1'b1;
            end
            if (ev_dclr) begin
              attn_q <= 1'b0;
              if (drv_attached) begin
                go_q           <= 1'b0;
                err_q          <= '0;
                tctl_q[TC_FCV] <= 1'b0;
              end
            end
          end
          RA_ERR:   err_q   <= bus_wdata;
          RA_MAINT: maint_q <= bus_wdata;
          RA_ATTN:  if (bus_wdata[0]) attn_q <= 1'b0;
          RA_FCNT: begin
            fcnt_q         <= bus_wdata;
            tctl_q[TC_FCV] <= 1'b1;
          end
          RA_TCTL:  tctl_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (ev_illegal_reg) begin
        err_q[E_BADREG] <= 1'b1;
        attn_q          <= 1'b1;
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign start_func = func_q;
  assign attn_out   = attn_q;
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker
  import tfr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_done,
  input logic             busy,
  input logic             go_q,
  input logic             pip_q,
  input logic             attn_q,
  input logic [REG_W-1:0] err_q,
  input logic [REG_W-1:0] tctl_q,
  input logic [REG_W-1:0] status_word,
  input logic             start_pulse,
  input logic             ev_start,
  input logic             ev_refused,
  input logic             ev_illegal_func,
  input logic             ev_illegal_reg,
  input logic             ev_dclr
);
  p_refuse_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refused |=> err_q[E_REFUSE]);
  p_refuse_keeps_tctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_refused && !op_done) |=> $stable(tctl_q));
  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_start);
  p_start_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (start_pulse && go_q && pip_q && tctl_q[TC_ACC] && err_q == '0));
  p_badfn_attn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal_func |=> (attn_q && err_q[E_BADFN]));
  p_badreg_attn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal_reg |=> (attn_q && err_q[E_BADREG]));
  p_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[8]);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[7] |-> !busy);
  p_done_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (!go_q && !pip_q && !tctl_q[TC_ACC]));
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_illegal_func, ev_dclr, ev_refused}));
endmodule

bind tape_fmt_regs tfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .busy(busy),
  .go_q(go_q), .pip_q(pip_q), .attn_q(attn_q), .err_q(err_q),
  .tctl_q(tctl_q), .status_word(status_word), .start_pulse(start_pulse),
  .ev_start(ev_start), .ev_refused(ev_refused),
  .ev_illegal_func(ev_illegal_func), .ev_illegal_reg(ev_illegal_reg),
  .ev_dclr(ev_dclr)
);

// File: tb/tape_fmt_regs_tb.sv
module tape_fmt_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        drv_attached = 1'b0, drv_wlock = 1'b0, drv_bot = 1'b0, drv_eot = 1'b0;
  logic        op_done = 1'b0;
  logic        start_pulse;
  logic [4:0]  start_func;
  logic        attn_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_fmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_attached(drv_attached), .drv_wlock(drv_wlock), .drv_bot(drv_bot),
    .drv_eot(drv_eot), .op_done(op_done), .start_pulse(start_pulse),
    .start_func(start_func), .attn_out(attn_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_status(bit att, bit wl, bit bt, bit et,
      bit go, bit pip, bit at, bit en, bit pe);
    logic [15:0] v;
    v = 16'h0100 + (at ? 16'h8000 : 16'h0) + (en ? 16'h4000 : 16'h0) + (pip ? 16'h2000 : 16'h0);
    if (att)
      v = v + 16'h1000 + (wl ? 16'h0800 : 16'h0) + (et ? 16'h0400 : 16'h0)
            + ((!go && !pip) ? 16'h0080 : 16'h0) + (pe ? 16'h0020 : 16'h0)
            + (!go ? 16'h0010 : 16'h0) + (bt ? 16'h0002 : 16'h0);
    return v;
  endfunction

  // class of a code: 0 idle, 1 clear, 2 plain start, 3 needs count, 4 loads count, 5 bad
  function automatic int code_kind(int c);
    if (c == 8'o00) return 0;
    if (c == 8'o04) return 1;
    if (c == 8'o10 || c == 8'o34 || c == 8'o37) return 4;
    if (c == 8'o30 || c == 8'o14 || c == 8'o15) return 3;
    if (c == 8'o01 || c == 8'o03 || c == 8'o12 || c == 8'o13 || c == 8'o24 || c == 8'o27) return 2;
    return 5;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(5'o11, v); chk("R11 tctl reset", v, 16'o002000);
    rd(5'o01, v); chk("R11 status reset", v, 16'o000400);
    rd(5'o00, v); chk("R1 ctrl reset", v, 16'h0800);

    drv_attached = 1'b1; drv_bot = 1'b1;
    rd(5'o01, v); chk("R9 attached idle", v, exp_status(1,0,1,0,0,0,0,0,1));

    // R1 function stored without GO
    wr(5'o00, 16'(8'o34) << 1);
    chk("R1 no start without go", {15'd0, start_pulse}, 16'd0);
    rd(5'o00, v); chk("R1 ctrl readback", v, 16'h0800 | 16'o70);

    // R2 R4 R5 R6 sweep of every code with frame-count-valid clear and set
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 2; f++) begin
        int k;
        bit st;
        logic [15:0] e;
        k = code_kind(c);
        wr(5'o00, 16'o11);            // drive clear with GO
        wr(5'o04, 16'd1);
        if (f == 1) wr(5'o05, 16'd5);
        wr(5'o00, (16'(c) << 1) | 16'd1);
        st = (k == 2) || (k == 4) || (k == 3 && f == 1);
        chk("R6 start pulse", {15'd0, start_pulse}, {15'd0, st});
        if (st) chk("R6 start func", {11'd0, start_func}, 16'(c));
        e = (k == 5) ? 16'h0001 : ((k == 3 && f == 0) ? 16'h0800 : 16'h0000);
        rd(5'o02, v); chk(k == 5 ? "R2 bad code error" : "R5 error reg", v, e);
        rd(5'o01, v);
        chk("R9 status after code", v, exp_status(1,0,1,0, st, st, k == 5, e != 0, 1));
        if (st && k == 4) begin
          rd(5'o05, v); chk("R4 count cleared", v, 16'd0);
          rd(5'o11, v); chk("R4 tctl valid and accel", v, 16'o002000 | 16'hC000);
        end
        if (st) finish_op();
        rd(5'o04, v); chk("R2 attention summary", v, (k == 5) ? 16'd1 : 16'd0);
      end
    end

    // R3 busy refusal, R12 completion
    wr(5'o00, 16'o11);
    wr(5'o00, (16'(8'o03) << 1) | 16'd1);
    wr(5'o11, 16'h0003);
    wr(5'o00, 16'o11);
    rd(5'o02, v); chk("R3 refused flag", v, 16'h0004);
    rd(5'o11, v); chk("R3 tctl untouched", v, 16'o002000 | 16'h8000);
    rd(5'o01, v); chk("R3 still busy", v, exp_status(1,0,1,0,1,1,0,1,1));
    finish_op();
    rd(5'o11, v); chk("R12 accel cleared", v, 16'o002000);
    rd(5'o01, v); chk("R12 idle after done", v, exp_status(1,0,1,0,0,0,0,1,1));

    // R8 frame count and attention writes
    wr(5'o02, 16'd0);
    wr(5'o05, 16'd7);
    rd(5'o11, v); chk("R8 count sets valid", v, 16'o002000 | 16'h4000);
    rd(5'o05, v); chk("R8 count value", v, 16'd7);

    // R11 undefined registers
    rd(5'o17, v); chk("R11 undefined reads zero", v, 16'd0);
    rd(5'o02, v); chk("R11 bad register flag", v, 16'h0002);
    rd(5'o04, v); chk("R11 attention raised", v, 16'd1);
    wr(5'o04, 16'd0);
    rd(5'o04, v); chk("R8 bit0 clear ignored", v, 16'd1);
    wr(5'o04, 16'd1);
    rd(5'o04, v); chk("R8 attention cleared", v, 16'd0);
    wr(5'o25, 16'hFFFF);
    chk("R11 undefined write attn", {15'd0, attn_out}, 16'd1);
    wr(5'o04, 16'd1);

    // R10 identity registers
    wr(5'o11, 16'o002003);
    rd(5'o10, v); chk("R10 serial", v, 16'o24);
    rd(5'o06, v); chk("R10 drive type", v, 16'o142054);
    rd(5'o07, v); chk("R10 look ahead", v, 16'd0);

    // R13 R7 unattached behaviour
    drv_attached = 1'b0;
    wr(5'o02, 16'd0);
    wr(5'o00, (16'(8'o03) << 1) | 16'd1);
    chk("R13 no start unattached", {15'd0, start_pulse}, 16'd0);
    wr(5'o00, (16'(8'o02) << 1) | 16'd1);
    rd(5'o02, v); chk("R13 no error unattached", v, 16'd0);
    rd(5'o17, v);
    wr(5'o00, 16'o11);
    rd(5'o04, v); chk("R7 unattached clear attn", v, 16'd0);
    rd(5'o02, v); chk("R7 unattached keeps error", v, 16'h0002);

    // R9 sweep of drive inputs with non-PE density
    wr(5'o11, 16'o001400);
    for (int m = 0; m < 16; m++) begin
      drv_attached = m[0]; drv_wlock = m[1]; drv_bot = m[2]; drv_eot = m[3];
      rd(5'o01, v);
      chk("R9 status inputs", v, exp_status(m[0], m[1], m[2], m[3], 0, 0, 0, 1, 0));
    end

    // R7 attached drive clear
    drv_attached = 1'b1; drv_wlock = 1'b0; drv_bot = 1'b0; drv_eot = 1'b0;
    wr(5'o05, 16'd1);
    wr(5'o00, (16'(8'o02) << 1) | 16'd1);
    chk("R2 bad code attention", {15'd0, attn_out}, 16'd1);
    wr(5'o00, 16'o11);
    rd(5'o02, v); chk("R7 clears error", v, 16'd0);
    rd(5'o04, v); chk("R7 clears attention", v, 16'd0);
    rd(5'o11, v); chk("R7 clears valid bit", v, 16'o001400);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule